// File: doc/BRIEF.md
# Scalar Load/Store Access Unit

This block carries out scalar memory loads and stores for a core with a 64-bit register file. It takes a raw 32-bit instruction word together with the two source operand values that the register file has already read. It decodes the word and forms the effective address as the base operand plus a sign-extended 12-bit offset. It then runs the access over a single-outstanding request/response memory port.

A load makes one read request of 1, 2, 4 or 8 bytes. When the read succeeds, the returned data is sign-extended or zero-extended to 64 bits and written back. A store makes two requests in turn. The first announces the address. Only when that succeeds does the second carry the data, which is the low bytes of the source operand.

The memory may report a fault in any phase. On a fault the unit writes nothing back, issues no further phase, and pulses a trap output that carries the address of the access. While an access is in flight the unit holds `busy` high, and any instruction offered during that time is not taken.

Top module: `lsu_unit`

## Requirements
- R1: An instruction is accepted only while `busy` is low. A word with opcode bits [6:0] = 0000011 is a load: funct3 bits [13:12] select the size (00 = 1 byte, 01 = 2, 10 = 4, 11 = 8) and bit 14 selects zero extension. A load with funct3 = 111 is ignored. A word with opcode 0100011 is a store, with funct3 000..011 selecting the size in the same way. Store funct3 values 100..111 and every other opcode are ignored, so no request is issued and `busy` stays low.
- R2: The access address is `rs1_val` plus a 12-bit signed offset. For a load the offset is bits [31:20]. For a store it is bits [31:25] placed above bits [11:7].
- R3: The cycle after a load is accepted, a read request appears with kind 00, the access address and the size code (0 = 1 byte, 1 = 2, 2 = 4, 3 = 8). If the response is good, `wb_valid` pulses for one cycle, in the cycle after the response. `wb_rd` is then bits [11:7] and `wb_data` is the low bytes of `mem_rsp_rdata`, sign-extended from their top bit.
- R4: A load with funct3 bit 14 set zero-extends the returned bytes instead.
- R5: A faulting load response causes no write-back. It causes a one-cycle `trap_valid` pulse, in the cycle after the response, with `trap_addr` equal to the access address.
- R6: A store first issues a request of kind 01 with its address and size. After a good response to it, the next cycle shows a request of kind 10 with the same address and size. Its `mem_req_wdata` holds the low 1, 2, 4 or 8 bytes of `rs2_val`, and all bits above them are zero.
- R7: A fault in the store address phase pulses `trap_valid` with the access address, and no data phase is issued.
- R8: A fault in the store data phase pulses `trap_valid` with the access address. A store never pulses `wb_valid`.
- R9: `busy` and `mem_req_valid` are high from the cycle after acceptance until the edge at which the final response is taken. The request fields stay unchanged while it waits. An instruction offered while `busy` is high is dropped.
- R10: A load whose destination index is 0 completes without a `wb_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An instruction is offered this cycle |
| issue_insn | input | 32 | Raw instruction word |
| rs1_val | input | 64 | Base operand value |
| rs2_val | input | 64 | Store source operand value |
| busy | output | 1 | An access is in flight; new instructions are not taken |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_kind | output | 2 | 00 read, 01 store address, 10 store data |
| mem_req_addr | output | 64 | Access address |
| mem_req_size | output | 2 | Size code, log2 of the byte count |
| mem_req_wdata | output | 64 | Store data, meaningful in the data phase |
| mem_rsp_valid | input | 1 | Response to the pending request |
| mem_rsp_fault | input | 1 | The response reports a fault |
| mem_rsp_rdata | input | 64 | Read data for a load response |
| wb_valid | output | 1 | Register write-back pulse |
| wb_rd | output | 5 | Destination register index |
| wb_data | output | 64 | Extended load value |
| trap_valid | output | 1 | Fault pulse |
| trap_addr | output | 64 | Address of the faulting access |

## Verification
The bench builds the unit with its default 64-bit data width. At that width the doubleword size code is legal, and the sign bit of each narrower size sits well below the top of the register, so sign and zero extension differ in a large, visible field. The memory model holds each response back for zero to three cycles and can fault either store phase independently. This exercises the held request fields, the dropped instructions offered during the wait, and the trap path from every phase.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    localparam int LSU_XLEN = 64;
    localparam int ILEN     = 32;
    localparam int RIDX_W   = 5;
    localparam int IMM_W    = 12;
    localparam int NSIZES   = 4;

    localparam logic [6:0] OPC_LOAD  = 7'b0000011;
    localparam logic [6:0] OPC_STORE = 7'b0100011;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        MK_READ = 2'd0,
        MK_ADDR = 2'd1,
        MK_DATA = 2'd2
    } mem_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SADDR,
        ST_SDATA
    } seq_state_e;

    typedef struct packed {
        logic              is_load;
        logic              is_store;
        acc_size_e         size;
        logic              zext;
        logic [RIDX_W-1:0] rd;
        logic [IMM_W-1:0]  imm;
    } op_t;

    function automatic logic [LSU_XLEN-1:0] sext_imm(input logic [IMM_W-1:0] imm);
        return {{(LSU_XLEN-IMM_W){imm[IMM_W-1]}}, imm};
    endfunction

endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
    import lsu_pkg::*;
(
    input  logic [ILEN-1:0] insn,
    output op_t             op
);
    logic [6:0] opc;
    logic [2:0] f3;
    logic       unused_rs1_field;

    assign opc = insn[6:0];
    assign f3  = insn[14:12];
    assign unused_rs1_field = ^insn[19:15];

    always_comb begin
        op          = '0;
        op.size     = acc_size_e'(f3[1:0]);
        op.zext     = f3[2];
        op.rd       = insn[11:7];
        op.is_load  = (opc == OPC_LOAD) && (f3 != 3'b111);
        op.is_store = (opc == OPC_STORE) && !f3[2];
        op.imm      = op.is_store ? {insn[31:25], insn[11:7]} : insn[31:20];
    end
endmodule

// File: rtl/lsu_extend.sv
module lsu_extend
    import lsu_pkg::*;
#(
    parameter int XLEN = LSU_XLEN
) (
    input  logic [XLEN-1:0] raw,
    input  acc_size_e       size,
    input  logic            zext,
    output logic [XLEN-1:0] ext
);
    logic [XLEN-1:0] cand [NSIZES];

    for (genvar g = 0; g < NSIZES; g++) begin : g_sz
        localparam int W = 8 << g;
        if (W >= XLEN) begin : g_full
            assign cand[g] = raw;
        end else begin : g_part
            assign cand[g] = {{(XLEN-W){zext ? 1'b0 : raw[W-1]}}, raw[W-1:0]};
        end
    end

    assign ext = cand[size];
endmodule

// File: rtl/lsu_seq.sv
module lsu_seq
    import lsu_pkg::*;
#(
    parameter int XLEN = LSU_XLEN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_load,
    input  logic              start_store,
    input  logic [XLEN-1:0]   ea,
    input  logic [XLEN-1:0]   st_data,
    input  acc_size_e         size_in,
    input  logic              zext_in,
    input  logic [RIDX_W-1:0] rd_in,
    input  logic [XLEN-1:0]   ext_data,
    output logic              busy,
    output logic              req_valid,
    output mem_kind_e         req_kind,
    output logic [XLEN-1:0]   req_addr,
    output acc_size_e         req_size,
    output logic [XLEN-1:0]   req_wdata,
    output logic              zext_q,
    input  logic              rsp_valid,
    input  logic              rsp_fault,
    output logic              wb_valid,
    output logic [RIDX_W-1:0] wb_rd,
    output logic [XLEN-1:0]   wb_data,
    output logic              trap_valid,
    output logic [XLEN-1:0]   trap_addr
);
    seq_state_e        state;
    logic [RIDX_W-1:0] rd_q;

    assign busy      = (state != ST_IDLE);
    assign req_valid = busy;

    always_comb begin
        case (state)
            ST_SADDR: req_kind = MK_ADDR;
            ST_SDATA: req_kind = MK_DATA;
            default:  req_kind = MK_READ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            req_addr   <= '0;
            req_size   <= SZ_BYTE;
            req_wdata  <= '0;
            zext_q     <= 1'b0;
            rd_q       <= '0;
            wb_valid   <= 1'b0;
            wb_rd      <= '0;
            wb_data    <= '0;
            trap_valid <= 1'b0;
            trap_addr  <= '0;
        end else begin
            wb_valid   <= 1'b0;
            trap_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start_load || start_store) begin
                        state     <= start_load ? ST_LOAD : ST_SADDR;
                        req_addr  <= ea;
                        req_size  <= size_in;
                        req_wdata <= st_data;
                        zext_q    <= zext_in;
                        rd_q      <= rd_in;
                    end
                end
                ST_LOAD: begin
                    if (rsp_valid) begin
                        state <= ST_IDLE;
                        if (rsp_fault) begin
                            trap_valid <= 1'b1;
                            trap_addr  <= req_addr;
                        end else if (rd_q != '0) begin
                            wb_valid <= 1'b1;
                            wb_rd    <= rd_q;
                            wb_data  <= ext_data;
                        end
                    end
                end
                ST_SADDR: begin
                    if (rsp_valid) begin
                        if (rsp_fault) begin
                            state      <= ST_IDLE;
                            trap_valid <= 1'b1;
                            trap_addr  <= req_addr;
                        end else begin
                            state <= ST_SDATA;
                        end
                    end
                end
                default: begin
                    if (rsp_valid) begin
                        state <= ST_IDLE;
                        if (rsp_fault) begin
                            trap_valid <= 1'b1;
                            trap_addr  <= req_addr;
                        end
                    end
                end
            endcase
        end
    end

    // R5
    wb_trap_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(wb_valid && trap_valid));

    // R10
    no_zero_wb_chk: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> (wb_rd != '0));

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !rsp_valid) |=>
            (req_valid && $stable(req_addr) && $stable(req_kind) && $stable(req_size)));

    // R7
    addr_fault_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == MK_ADDR && rsp_valid && rsp_fault) |=>
            (trap_valid && !req_valid));

    // R6
    data_after_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == MK_DATA && !$past(req_valid && req_kind == MK_DATA)) |->
            $past(req_valid && req_kind == MK_ADDR && rsp_valid && !rsp_fault));

    // R5
    load_fault_trap_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == MK_READ && rsp_valid && rsp_fault) |=>
            (trap_valid && !wb_valid && trap_addr == $past(req_addr)));
endmodule

// File: rtl/lsu_unit.sv
module lsu_unit
    import lsu_pkg::*;
#(
    parameter int XLEN = LSU_XLEN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_valid,
    input  logic [ILEN-1:0]   issue_insn,
    input  logic [XLEN-1:0]   rs1_val,
    input  logic [XLEN-1:0]   rs2_val,
    output logic              busy,
    output logic              mem_req_valid,
    output logic [1:0]        mem_req_kind,
    output logic [XLEN-1:0]   mem_req_addr,
    output logic [1:0]        mem_req_size,
    output logic [XLEN-1:0]   mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic              mem_rsp_fault,
    input  logic [XLEN-1:0]   mem_rsp_rdata,
    output logic              wb_valid,
    output logic [RIDX_W-1:0] wb_rd,
    output logic [XLEN-1:0]   wb_data,
    output logic              trap_valid,
    output logic [XLEN-1:0]   trap_addr
);
    localparam int NBYTES = XLEN / 8;

    op_t             op;
    logic [XLEN-1:0] ea;
    logic [XLEN-1:0] st_data;
    logic [XLEN-1:0] ext_data;
    mem_kind_e       kind_w;
    acc_size_e       size_w;
    logic            zext_w;
    logic            go_load;
    logic            go_store;

    lsu_decode u_dec (
        .insn (issue_insn),
        .op   (op)
    );

    assign ea       = rs1_val + XLEN'(sext_imm(op.imm));
    assign go_load  = issue_valid && !busy && op.is_load;
    assign go_store = issue_valid && !busy && op.is_store;

    always_comb begin
        for (int b = 0; b < NBYTES; b++) begin
            st_data[b*8 +: 8] = (b < (1 << op.size)) ? rs2_val[b*8 +: 8] : 8'h00;
        end
    end

    lsu_extend #(.XLEN(XLEN)) u_ext (
        .raw  (mem_rsp_rdata),
        .size (size_w),
        .zext (zext_w),
        .ext  (ext_data)
    );

    lsu_seq #(.XLEN(XLEN)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_load  (go_load),
        .start_store (go_store),
        .ea          (ea),
        .st_data     (st_data),
        .size_in     (op.size),
        .zext_in     (op.zext),
        .rd_in       (op.rd),
        .ext_data    (ext_data),
        .busy        (busy),
        .req_valid   (mem_req_valid),
        .req_kind    (kind_w),
        .req_addr    (mem_req_addr),
        .req_size    (size_w),
        .req_wdata   (mem_req_wdata),
        .zext_q      (zext_w),
        .rsp_valid   (mem_rsp_valid),
        .rsp_fault   (mem_rsp_fault),
        .wb_valid    (wb_valid),
        .wb_rd       (wb_rd),
        .wb_data     (wb_data),
        .trap_valid  (trap_valid),
        .trap_addr   (trap_addr)
    );

    assign mem_req_kind = kind_w;
    assign mem_req_size = size_w;
endmodule

// File: tb/lsu_unit_bench.sv
`timescale 1ns/1ps
module lsu_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue_valid = 1'b0;
    logic [31:0] issue_insn = '0;
    logic [63:0] rs1_val = '0;
    logic [63:0] rs2_val = '0;
    logic        busy, mem_req_valid;
    logic [1:0]  mem_req_kind, mem_req_size;
    logic [63:0] mem_req_addr, mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic        mem_rsp_fault = 1'b0;
    logic [63:0] mem_rsp_rdata = '0;
    logic        wb_valid, trap_valid;
    logic [4:0]  wb_rd;
    logic [63:0] wb_data, trap_addr;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    lsu_unit u_lsu_unit (
        .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_insn(issue_insn),
        .rs1_val(rs1_val), .rs2_val(rs2_val), .busy(busy),
        .mem_req_valid(mem_req_valid), .mem_req_kind(mem_req_kind),
        .mem_req_addr(mem_req_addr), .mem_req_size(mem_req_size),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_fault(mem_rsp_fault), .mem_rsp_rdata(mem_rsp_rdata),
        .wb_valid(wb_valid), .wb_rd(wb_rd), .wb_data(wb_data),
        .trap_valid(trap_valid), .trap_addr(trap_addr)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_load(input logic [4:0] rd, input logic [2:0] f3,
                                             input logic [11:0] imm);
        return {imm, 5'd1, f3, rd, 7'b0000011};
    endfunction

    function automatic logic [31:0] enc_store(input logic [2:0] f3, input logic [11:0] imm);
        return {imm[11:5], 5'd2, 5'd1, f3, imm[4:0], 7'b0100011};
    endfunction

    function automatic logic [63:0] sx12(input logic [11:0] imm);
        return {{52{imm[11]}}, imm};
    endfunction

    function automatic logic [63:0] model_ext(input logic [63:0] d, input logic [1:0] sz,
                                              input bit uns);
        case (sz)
            2'd0: return uns ? {56'd0, d[7:0]}  : {{56{d[7]}},  d[7:0]};
            2'd1: return uns ? {48'd0, d[15:0]} : {{48{d[15]}}, d[15:0]};
            2'd2: return uns ? {32'd0, d[31:0]} : {{32{d[31]}}, d[31:0]};
            default: return d;
        endcase
    endfunction

    function automatic logic [63:0] model_low(input logic [63:0] d, input logic [1:0] sz);
        return model_ext(d, sz, 1'b1);
    endfunction

    task automatic phase(input logic [1:0] kind, input logic [63:0] addr,
                         input logic [1:0] size, input logic [63:0] wdata,
                         input int delay, input bit fault, input logic [63:0] rdata,
                         input bit hold);
        string tg;
        tg = (kind == 2'd0) ? "R3" : "R6";
        if (hold) begin
            issue_valid = 1'b1;
            issue_insn  = enc_load(5'd9, 3'b011, 12'h010);
        end
        for (int i = 0; i < delay; i++) begin
            chk("R9", "busy while waiting", 64'(busy), 64'd1);
            chk("R9", "request held", {mem_req_valid, mem_req_kind, mem_req_size},
                {1'b1, kind, size});
            chk("R9", "address held", mem_req_addr, addr);
            chk("R9", "no early pulse", {wb_valid, trap_valid}, 64'd0);
            @(negedge clk);
        end
        chk(tg, "request kind/size", {mem_req_valid, mem_req_kind, mem_req_size},
            {1'b1, kind, size});
        chk("R2", "request address", mem_req_addr, addr);
        if (kind == 2'd2) chk("R6", "store data", mem_req_wdata, wdata);
        mem_rsp_valid = 1'b1;
        mem_rsp_fault = fault;
        mem_rsp_rdata = rdata;
        issue_valid   = 1'b0;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        mem_rsp_fault = 1'b0;
        mem_rsp_rdata = '0;
    endtask

    task automatic do_load(input logic [4:0] rd, input logic [2:0] f3, input logic [11:0] imm,
                           input logic [63:0] base, input logic [63:0] rdata,
                           input int delay, input bit fault, input bit hold);
        logic [63:0] ea;
        ea = base + sx12(imm);
        issue_valid = 1'b1;
        issue_insn  = enc_load(rd, f3, imm);
        rs1_val     = base;
        rs2_val     = 64'hDEAD_BEEF_0BAD_F00D;
        @(negedge clk);
        issue_valid = 1'b0;
        phase(2'd0, ea, f3[1:0], 64'd0, delay, fault, rdata, hold);
        chk("R9", "idle after load", {busy, mem_req_valid}, 64'd0);
        if (fault) begin
            chk("R5", "trap pulse / no write", {trap_valid, wb_valid}, 64'b10);
            chk("R5", "trap address", trap_addr, ea);
        end else if (rd == 5'd0) begin
            chk("R10", "no write to index 0", {wb_valid, trap_valid}, 64'd0);
        end else begin
            chk("R3", "write pulse", {wb_valid, trap_valid, wb_rd}, {1'b1, 1'b0, rd});
            chk(f3[2] ? "R4" : "R3", "extended data", wb_data, model_ext(rdata, f3[1:0], f3[2]));
        end
        @(negedge clk);
        chk("R9", "quiet after load", {busy, mem_req_valid, wb_valid, trap_valid}, 64'd0);
    endtask

    task automatic do_store(input logic [2:0] f3, input logic [11:0] imm,
                            input logic [63:0] base, input logic [63:0] src,
                            input int da, input bit fa, input int db, input bit fb,
                            input bit hold);
        logic [63:0] ea;
        ea = base + sx12(imm);
        issue_valid = 1'b1;
        issue_insn  = enc_store(f3, imm);
        rs1_val     = base;
        rs2_val     = src;
        @(negedge clk);
        issue_valid = 1'b0;
        phase(2'd1, ea, f3[1:0], 64'd0, da, fa, 64'hFFFF_FFFF_FFFF_FFFF, hold);
        if (fa) begin
            chk("R7", "idle, no data phase", {busy, mem_req_valid}, 64'd0);
            chk("R7", "trap pulse", {trap_valid, wb_valid}, 64'b10);
            chk("R7", "trap address", trap_addr, ea);
        end else begin
            chk("R6", "no pulse between phases", {wb_valid, trap_valid}, 64'd0);
            phase(2'd2, ea, f3[1:0], model_low(src, f3[1:0]), db, fb,
                  64'hFFFF_FFFF_FFFF_FFFF, hold);
            chk("R9", "idle after store", {busy, mem_req_valid}, 64'd0);
            if (fb) begin
                chk("R8", "trap pulse", {trap_valid, wb_valid}, 64'b10);
                chk("R8", "trap address", trap_addr, ea);
            end else begin
                chk("R8", "no pulse on good store", {trap_valid, wb_valid}, 64'd0);
            end
        end
        @(negedge clk);
        chk("R9", "quiet after store", {busy, mem_req_valid, wb_valid, trap_valid}, 64'd0);
    endtask

    task automatic do_ignored(input logic [31:0] insn);
        issue_valid = 1'b1;
        issue_insn  = insn;
        rs1_val     = 64'h4000;
        @(negedge clk);
        issue_valid = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk("R1", "ignored word starts nothing",
                {busy, mem_req_valid, wb_valid, trap_valid}, 64'd0);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R9", "reset state", {busy, mem_req_valid, wb_valid, trap_valid}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R9", "idle after reset", {busy, mem_req_valid, wb_valid, trap_valid}, 64'd0);

        // R3 signed loads of every size, negative and positive offsets
        do_load(5'd5, 3'b000, 12'hFFC, 64'h1000, 64'h0123_4567_89AB_CD80, 0, 1'b0, 1'b0);
        do_load(5'd6, 3'b001, 12'h7FF, 64'h2000, 64'h0000_0000_0000_8001, 1, 1'b0, 1'b0);
        do_load(5'd7, 3'b010, 12'h800, 64'h10_0000, 64'hAAAA_BBBB_8000_0000, 2, 1'b0, 1'b0);
        do_load(5'd8, 3'b011, 12'h008, 64'h3000, 64'h8765_4321_0FED_CBA9, 0, 1'b0, 1'b0);
        do_load(5'd9, 3'b010, 12'h004, 64'h3000, 64'h0000_0000_7FFF_FFFF, 0, 1'b0, 1'b0);
        // R4 unsigned loads
        do_load(5'd10, 3'b100, 12'hFFC, 64'h1000, 64'h0123_4567_89AB_CD80, 2, 1'b0, 1'b0);
        do_load(5'd11, 3'b101, 12'h002, 64'h1000, 64'hFFFF_FFFF_FFFF_8001, 0, 1'b0, 1'b0);
        do_load(5'd31, 3'b110, 12'h000, 64'h1000, 64'h1111_1111_8000_0000, 3, 1'b0, 1'b0);
        // R5 faulting load, with an instruction offered during the wait (R9)
        do_load(5'd12, 3'b011, 12'h010, 64'h8000, 64'h5555, 1, 1'b1, 1'b1);
        // R10 load to index 0
        do_load(5'd0, 3'b000, 12'h000, 64'h100, 64'hFF, 1, 1'b0, 1'b0);
        // R9 held offers during a good load
        do_load(5'd13, 3'b001, 12'h020, 64'h500, 64'h0000_0000_0000_7F00, 3, 1'b0, 1'b1);

        // R6 stores of every size, split offset fields
        do_store(3'b000, 12'h8A5, 64'h0010_0000, 64'h1122_3344_5566_7788, 0, 1'b0, 0, 1'b0, 1'b0);
        do_store(3'b001, 12'h07F, 64'h2000, 64'h1122_3344_5566_7788, 1, 1'b0, 2, 1'b0, 1'b0);
        do_store(3'b010, 12'hFE0, 64'h2000, 64'hCAFE_BABE_DEAD_BEEF, 0, 1'b0, 1, 1'b0, 1'b0);
        do_store(3'b011, 12'h018, 64'h2000, 64'hCAFE_BABE_DEAD_BEEF, 2, 1'b0, 0, 1'b0, 1'b1);
        // R7 address-phase fault
        do_store(3'b011, 12'h040, 64'h9000, 64'h1234, 1, 1'b1, 0, 1'b0, 1'b1);
        do_store(3'b000, 12'hFFF, 64'h9000, 64'h1234, 0, 1'b1, 0, 1'b0, 1'b0);
        // R8 data-phase fault
        do_store(3'b010, 12'h100, 64'hA000, 64'h5678, 1, 1'b0, 3, 1'b1, 1'b1);
        do_store(3'b001, 12'h002, 64'hA000, 64'h5678, 0, 1'b0, 0, 1'b1, 1'b0);

        // R1 words that must be ignored
        do_ignored(enc_load(5'd4, 3'b111, 12'h000));
        do_ignored(enc_store(3'b100, 12'h000));
        do_ignored(enc_store(3'b111, 12'h000));
        do_ignored({7'd0, 5'd2, 5'd1, 3'b000, 5'd3, 7'b0110011});
        // R1 a good load right after the ignored words
        do_load(5'd14, 3'b000, 12'h001, 64'h0, 64'h0000_0000_0000_0042, 0, 1'b0, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule